// File: doc/BRIEF.md
# Exception-Level Event Count Filter

This unit sits in front of a performance event counter and decides, once per clock, whether the event seen in that cycle may be counted. It looks at the privilege level the core is running at (levels 0 to 2), at whether the core is currently executing a guest, and at a strap that says which host model is in use. In one model the host kernel runs at level 2. In the other, the host kernel runs at level 1 and level 2 is a thin hypervisor layer.

Five exclusion attributes describe what the user wants left out of the count:
- user code
- kernel code
- hypervisor code
- the host
- the guest

The meaning of some attributes depends on the host model. Part of the host/guest separation is applied by switching the enables when the core enters or leaves a guest. Guest entry and exit arrive as single-cycle pulses. The unit keeps its own host/guest state from these pulses and drives one registered count-enable bit.

Top module: `el_event_filter`

## Requirements
- R1: After reset the unit is in host state and `count_en` is 0. Level encoding: `cur_el` 0, 1 and 2 select levels 0, 1 and 2. The value 3 is never counted.
- R2: `excl_user` blocks counting at level 0 in both host models and in both host and guest state.
- R3: `excl_kernel` blocks level 1 in every case. On the level-2-kernel host (`vhe_host`=1) in host state it also blocks level 2. On the level-1-kernel host (`vhe_host`=0) it does not affect level 2.
- R4: In guest state, level 2 is never counted, whatever the attributes.
- R5: `excl_hv` blocks level 2 only on the level-1-kernel host (`vhe_host`=0) in host state. It has no effect on the level-2-kernel host or in guest state.
- R6: With `vhe_host`=0, `excl_host` blocks all levels in host state and `excl_guest` blocks all levels in guest state. This is the whole event being disabled or re-enabled at guest entry and exit.
- R7: With `vhe_host`=1:
  - `excl_guest` blocks level 1 in both states.
  - `excl_host` blocks levels 0 and 2 in host state.
  - At level 0 the blocking attribute follows the state: `excl_host` in host state and `excl_guest` in guest state.
- R8: Host/guest state is set by `guest_enter` and cleared by `guest_exit`. When both pulses arrive in the same cycle, the exit wins.
- R9: `count_en` is registered. It reflects level, strap and attributes sampled at the previous rising edge. A guest pulse reaches `count_en` at the second edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_el | input | 2 | Current privilege level |
| vhe_host | input | 1 | Strap: 1 = host kernel at level 2, 0 = host kernel at level 1 |
| guest_enter | input | 1 | Single-cycle guest entry pulse |
| guest_exit | input | 1 | Single-cycle guest exit pulse |
| excl_user | input | 1 | Exclude user code |
| excl_kernel | input | 1 | Exclude kernel code |
| excl_hv | input | 1 | Exclude hypervisor code |
| excl_host | input | 1 | Exclude the host |
| excl_guest | input | 1 | Exclude the guest |
| count_en | output | 1 | Registered count enable |

## Verification
The bench applies every combination of the following and compares `count_en` with a table-style reference function:
- both strap values
- both host/guest states
- all four level codes
- all 32 attribute patterns

This sweep tells the two host models apart at levels 1 and 2, where the same attribute maps to different levels. It also shows that `excl_hv` and the level-2 path are inert in guest state. Further patterns cover:
- guest entry and exit pulses, including both pulses in the same cycle, to separate exit priority from entry priority
- a single-step check that the output waits one edge after an input change

// File: rtl/el_event_filter.sv
module el_event_filter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cur_el,
  input  logic       vhe_host,
  input  logic       guest_enter,
  input  logic       guest_exit,
  input  logic       excl_user,
  input  logic       excl_kernel,
  input  logic       excl_hv,
  input  logic       excl_host,
  input  logic       excl_guest,
  output logic       count_en
);

  logic guest_q;
  logic ok_lvl0, ok_lvl1, ok_lvl2, ok_now;

  always_ff @(posedge clk) begin
    if (!rst_n)           guest_q <= 1'b0;
    else if (guest_exit)  guest_q <= 1'b0;
    else if (guest_enter) guest_q <= 1'b1;
  end

  // Level 0: switched between host and guest exclusion on entry/exit.
  assign ok_lvl0 = !excl_user && (guest_q ? !excl_guest : !excl_host);

  // Level 1: guest exclusion is a fixed mask on the level-2-kernel host.
  assign ok_lvl1 = !excl_kernel &&
                   ((guest_q || vhe_host) ? !excl_guest : !excl_host);

  // Level 2: never in a guest; kernel or hypervisor depending on host model.
  assign ok_lvl2 = !guest_q && !excl_host &&
                   (vhe_host ? !excl_kernel : !excl_hv);

  always_comb begin
    case (cur_el)
      2'd0:    ok_now = ok_lvl0;
      2'd1:    ok_now = ok_lvl1;
      2'd2:    ok_now = ok_lvl2;
      default: ok_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_en <= 1'b0;
    else        count_en <= ok_now;
  end

endmodule

module el_event_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cur_el,
  input logic       guest_q,
  input logic       guest_enter,
  input logic       guest_exit,
  input logic       excl_user,
  input logic       excl_kernel,
  input logic       count_en
);

  AST_USER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_el == 2'd0 && excl_user) |=> !count_en); // R2

  AST_KERNEL_LVL1_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_el == 2'd1 && excl_kernel) |=> !count_en); // R3

  AST_GUEST_LVL2_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_el == 2'd2 && guest_q) |=> !count_en); // R4

  AST_LVL3_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_el == 2'd3) |=> !count_en); // R1

  AST_EXIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    guest_exit |=> !guest_q); // R8

  AST_ENTER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (guest_enter && !guest_exit) |=> guest_q); // R8

  AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!guest_enter && !guest_exit) |=> $stable(guest_q)); // R8

endmodule

bind el_event_filter el_event_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cur_el(cur_el), .guest_q(guest_q),
  .guest_enter(guest_enter), .guest_exit(guest_exit),
  .excl_user(excl_user), .excl_kernel(excl_kernel), .count_en(count_en)
);

// File: tb/test_el_event_filter.sv
module test_el_event_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cur_el = 2'd0;
  logic vhe_host = 1'b0, guest_enter = 1'b0, guest_exit = 1'b0;
  logic excl_user = 1'b0, excl_kernel = 1'b0, excl_hv = 1'b0;
  logic excl_host = 1'b0, excl_guest = 1'b0;
  logic count_en;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  el_event_filter i_el_event_filter (
    .clk(clk), .rst_n(rst_n), .cur_el(cur_el), .vhe_host(vhe_host),
    .guest_enter(guest_enter), .guest_exit(guest_exit),
    .excl_user(excl_user), .excl_kernel(excl_kernel), .excl_hv(excl_hv),
    .excl_host(excl_host), .excl_guest(excl_guest), .count_en(count_en)
  );

  function automatic bit ref_en(bit v, bit g, int lvl, logic [4:0] a);
    bit u = a[0], k = a[1], hv = a[2], ho = a[3], gu = a[4];
    if (lvl == 3) return 0;
    if (g) begin
      if (lvl == 2) return 0;
      if (gu) return 0;
      return (lvl == 0) ? !u : !k;
    end
    if (v) begin
      case (lvl)
        0: return !u && !ho;
        1: return !k && !gu;
        default: return !k && !ho;
      endcase
    end
    if (ho) return 0;
    case (lvl)
      0: return !u;
      1: return !k;
      default: return !hv;
    endcase
  endfunction

  task automatic chk(bit exp, string req);
    checks++;
    if (count_en !== exp) begin
      fails++;
      $display("FAIL %s: count_en=%b expected %b (el=%0d vhe=%b attrs=%b)",
               req, count_en, exp, cur_el, vhe_host,
               {excl_guest, excl_host, excl_hv, excl_kernel, excl_user});
    end
  endtask

  task automatic set_attrs(logic [4:0] a);
    {excl_guest, excl_host, excl_hv, excl_kernel, excl_user} = a;
  endtask

  task automatic pulse(bit en, bit ex);
    @(negedge clk); guest_enter = en; guest_exit = ex;
    @(negedge clk); guest_enter = 0; guest_exit = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(0, "R1 reset");
    rst_n = 1;
    @(negedge clk);
    chk(1, "R1 host state after reset, el0 no exclusions");

    for (int v = 0; v < 2; v++) begin
      vhe_host = v[0];
      for (int g = 0; g < 2; g++) begin
        pulse(g == 1, g == 0);
        for (int lvl = 0; lvl < 4; lvl++) begin
          for (int a = 0; a < 32; a++) begin
            cur_el = 2'(lvl); set_attrs(5'(a));
            @(negedge clk);
            // covers R2 R3 R4 R5 R6 R7 R1
            chk(ref_en(v[0], g[0], lvl, 5'(a)), "R2-sweep");
          end
        end
      end
    end

    // R8: both pulses together -> host state (level 2 countable in host)
    vhe_host = 0; cur_el = 2'd2; set_attrs(5'd0);
    pulse(1, 0);
    @(negedge clk); chk(0, "R8 entry gives guest state");
    pulse(1, 1);
    @(negedge clk); chk(1, "R8 exit wins over entry");

    // R9: latency of one edge for level change, two for guest pulse
    @(negedge clk); cur_el = 2'd3;
    #5 chk(1, "R9 output holds before edge");
    @(negedge clk); chk(0, "R9 output follows after one edge");
    cur_el = 2'd2;
    @(negedge clk); chk(1, "R9 back to level 2");
    guest_enter = 1;
    @(negedge clk); guest_enter = 0;
    chk(1, "R9 guest pulse not yet visible");
    @(negedge clk); chk(0, "R9 guest pulse visible at second edge");

    // R5: excl_hv inert on level-2-kernel host
    pulse(0, 1); vhe_host = 1; excl_hv = 1;
    @(negedge clk); chk(1, "R5 hv ignored with vhe_host");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule